// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block turns a stream of NRZ data bits into a line signal in one of four codings: plain NRZ, NRZI, return-to-zero, or Manchester. It runs from a clock at twice the bit rate, so each bit occupies two clock cycles. The first cycle is the lead half and the second is the trail half. On the edge that opens a bit, the block samples the data input and the mode input together. It holds both for the whole bit, so the upstream logic only has to present a new bit once every two cycles.

The core is a Moore machine. Its state register holds the line level and the half-bit phase directly, so `line_out` and `sec_half` both come straight from flip-flops and cannot glitch. There are five states:

- `ST_IDLE` is the state after reset: line low, no bit in flight.
- `ST_LEAD_LO` and `ST_LEAD_HI` show the lead half of a bit at a low or high level.
- `ST_TRAIL_LO` and `ST_TRAIL_HI` show the trail half.

The transitions are as follows:

- From `ST_IDLE` or either trail state, the next edge samples a new bit. It moves to the lead state whose level the coding picks for that bit (the *open-bit* transition).
- From either lead state, the next edge moves to the trail state whose level the coding picks for the held bit (the *mid-bit* transition).

A separate reference register keeps the NRZI level between bits.

Top module: `line_encoder`

## Requirements
- R1: While `rst_n` is low, `line_out` and `sec_half` are 0 and the NRZI reference level is cleared to 0. The first rising edge after `rst_n` goes high samples a new bit.
- R2: `sec_half` is 0 during the lead half of each bit and 1 during the trail half. The two values alternate cycle by cycle once bits are flowing, and a sampling edge is always followed by a lead half.
- R3: `data_in` and `mode` are sampled only on the edge that opens a bit. Changing them during the lead half has no effect on the trail half of the same bit.
- R4: Mode 2'b00 (NRZ) drives the data bit on the line for both halves.
- R5: Mode 2'b01 (NRZI) drives the same level for both halves. A 0 repeats the NRZI reference level and a 1 drives its complement. The level driven becomes the new reference.
- R6: Mode 2'b10 (RZ) drives the data bit in the lead half and 0 in the trail half.
- R7: Mode 2'b11 (Manchester) drives the data bit in the lead half and its complement in the trail half. Every bit therefore has a mid-bit transition.
- R8: The NRZI reference level changes only on bits sent in NRZI mode. Bits in other modes leave it untouched, so a later NRZI bit continues from the last NRZI level.
- R9: `line_out` changes only on the edge after the bit or half it belongs to opens. A bit presented before a sampling edge appears on the line during the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | NRZ data bit, sampled on the edge that opens a bit |
| mode | input | 2 | Coding select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| line_out | output | 1 | Registered encoded line level |
| sec_half | output | 1 | 1 while the line shows the trail half of a bit |

## Verification
Two things meet on the same edge: the trail half of one bit is emitted, and the next bit is sampled. At that moment the NRZI reference is updated and the new bit's mode replaces the old one. The bench provokes this collision in two ways. It runs back-to-back bits whose mode changes from one bit to the next, including NRZI bits separated by other modes. It also scrambles `data_in` and `mode` during the lead half. The trail half must follow the held bit and the stored reference, and the next lead half must follow the freshly sampled inputs. Both are compared against a bench model that tracks its own NRZI level.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
    localparam int MODE_W    = 2;
    localparam int ST_W      = 3;
    localparam int LVL_BIT   = 0;
    localparam int TRAIL_BIT = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NRZ  = 2'b00,
        MODE_NRZI = 2'b01,
        MODE_RZ   = 2'b10,
        MODE_MAN  = 2'b11
    } line_mode_e;

    // Bit LVL_BIT carries the line level, bit TRAIL_BIT the half-bit phase.
    typedef enum logic [ST_W-1:0] {
        ST_IDLE     = 3'b000,
        ST_LEAD_LO  = 3'b010,
        ST_LEAD_HI  = 3'b011,
        ST_TRAIL_LO = 3'b100,
        ST_TRAIL_HI = 3'b101
    } enc_state_e;
endpackage

// File: rtl/lenc_bit_hold.sv
module lenc_bit_hold
    import lenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       data_in,
    input  line_mode_e mode_now,
    output logic       bit_q,
    output line_mode_e mode_q
);
    // Data and mode are captured together and held for both halves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= 1'b0;
            mode_q <= MODE_NRZ;
        end else if (take) begin
            bit_q  <= data_in;
            mode_q <= mode_now;
        end
    end
endmodule

// File: rtl/lenc_nrzi_ref.sv
module lenc_nrzi_ref
    import lenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       data_in,
    input  line_mode_e mode_now,
    output logic       ref_q,
    output logic       ref_next
);
    // A one toggles the level; a zero repeats it.
    always_comb ref_next = ref_q ^ data_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (take && (mode_now == MODE_NRZI)) begin
            ref_q <= ref_next;
        end
    end
endmodule

// File: rtl/lenc_level_pick.sv
module lenc_level_pick
    import lenc_pkg::*;
(
    input  line_mode_e mode_now,
    input  logic       data_now,
    input  logic       ref_next,
    input  line_mode_e mode_q,
    input  logic       bit_q,
    input  logic       ref_q,
    output logic       lead_lvl,
    output logic       trail_lvl
);
    // Lead half: uses the live inputs, since it is computed on the sampling edge.
    always_comb begin
        unique case (mode_now)
            MODE_NRZ:  lead_lvl = data_now;
            MODE_NRZI: lead_lvl = ref_next;
            MODE_RZ:   lead_lvl = data_now;
            MODE_MAN:  lead_lvl = data_now;
            default:   lead_lvl = 1'b0;
        endcase
    end

    // Trail half: uses the held bit; the NRZI reference has already advanced.
    always_comb begin
        unique case (mode_q)
            MODE_NRZ:  trail_lvl = bit_q;
            MODE_NRZI: trail_lvl = ref_q;
            MODE_RZ:   trail_lvl = 1'b0;
            MODE_MAN:  trail_lvl = ~bit_q;
            default:   trail_lvl = 1'b0;
        endcase
    end
endmodule

// File: rtl/lenc_fsm.sv
module lenc_fsm
    import lenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lead_lvl,
    input  logic trail_lvl,
    output logic take,
    output logic line_out,
    output logic sec_half
);
    enc_state_e state_q;
    enc_state_e state_d;

    // Next-state logic: open-bit and mid-bit transitions.
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_TRAIL_LO, ST_TRAIL_HI: begin
                take    = 1'b1;
                state_d = lead_lvl ? ST_LEAD_HI : ST_LEAD_LO;
            end
            ST_LEAD_LO, ST_LEAD_HI: begin
                take    = 1'b0;
                state_d = trail_lvl ? ST_TRAIL_HI : ST_TRAIL_LO;
            end
            default: begin
                take    = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs: taken straight from state flip-flops.
    always_comb begin
        line_out = state_q[LVL_BIT];
        sec_half = state_q[TRAIL_BIT];
    end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
    import lenc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_in,
    input  logic [MODE_W-1:0]   mode,
    output logic                line_out,
    output logic                sec_half
);
    line_mode_e mode_now;
    line_mode_e mode_q;
    logic       take;
    logic       bit_q;
    logic       ref_q;
    logic       ref_next;
    logic       lead_lvl;
    logic       trail_lvl;

    always_comb mode_now = line_mode_e'(mode);

    lenc_bit_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .data_in  (data_in),
        .mode_now (mode_now),
        .bit_q    (bit_q),
        .mode_q   (mode_q)
    );

    lenc_nrzi_ref u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .data_in  (data_in),
        .mode_now (mode_now),
        .ref_q    (ref_q),
        .ref_next (ref_next)
    );

    lenc_level_pick u_pick (
        .mode_now  (mode_now),
        .data_now  (data_in),
        .ref_next  (ref_next),
        .mode_q    (mode_q),
        .bit_q     (bit_q),
        .ref_q     (ref_q),
        .lead_lvl  (lead_lvl),
        .trail_lvl (trail_lvl)
    );

    lenc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_lvl  (lead_lvl),
        .trail_lvl (trail_lvl),
        .take      (take),
        .line_out  (line_out),
        .sec_half  (sec_half)
    );
endmodule

// File: rtl/lenc_checker.sv
module lenc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       take,
    input logic       line_out,
    input logic       sec_half,
    input logic [1:0] mode_q
);
    assert_phase_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_half |=> !sec_half);

    assert_take_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !sec_half);

    assert_nrz_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_half && mode_q == 2'b00) |-> $stable(line_out));

    assert_nrzi_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_half && mode_q == 2'b01) |-> $stable(line_out));

    assert_rz_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_half && mode_q == 2'b10) |-> !line_out);

    assert_man_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_half && mode_q == 2'b11) |-> (line_out != $past(line_out)));
endmodule

bind line_encoder lenc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .line_out (line_out),
    .sec_half (sec_half),
    .mode_q   (mode_q)
);

// File: tb/sim_line_encoder.sv
`timescale 1ns/1ps
module sim_line_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       line_out;
    logic       sec_half;

    int n_run  = 0;
    int n_fail = 0;
    bit ref_m  = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    line_encoder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .mode     (mode),
        .line_out (line_out),
        .sec_half (sec_half)
    );

    function automatic bit exp_lead(logic [1:0] m, bit d, bit r);
        case (m)
            2'b01:   return r ^ d;
            default: return d;
        endcase
    endfunction

    function automatic bit exp_trail(logic [1:0] m, bit d, bit r_after);
        case (m)
            2'b00:   return d;
            2'b01:   return r_after;
            2'b10:   return 1'b0;
            default: return ~d;
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(logic act, bit exp, string req, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Enter and leave at a falling edge; the next rising edge samples the bit.
    task automatic send(bit d, logic [1:0] m, bit scramble);
        bit    lead;
        bit    trail;
        string tg;
        tg      = mode_tag(m);
        data_in = d;
        mode    = m;
        lead    = exp_lead(m, d, ref_m);
        if (m == 2'b01) ref_m = ref_m ^ d;   // R8: only NRZI moves the reference
        trail   = exp_trail(m, d, ref_m);
        @(posedge clk);
        @(negedge clk);
        check(line_out, lead, {tg, " R9"}, "lead half level");
        check(sec_half, 1'b0, "R2", "lead half phase");
        if (scramble) begin
            data_in = ~d;
            mode    = 2'($urandom);
        end
        @(posedge clk);
        @(negedge clk);
        check(line_out, trail, scramble ? {tg, " R3"} : tg, "trail half level");
        check(sec_half, 1'b1, "R2", "trail half phase");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_m = 1'b0;
        repeat (2) @(negedge clk);
        check(line_out, 1'b0, "R1", "line low in reset");
        check(sec_half, 1'b0, "R1", "phase low in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R4 NRZ
        send(1'b1, 2'b00, 1'b0);
        send(1'b0, 2'b00, 1'b0);
        // R5 NRZI: ones toggle, zeros repeat
        send(1'b1, 2'b01, 1'b0);
        send(1'b1, 2'b01, 1'b0);
        send(1'b0, 2'b01, 1'b0);
        send(1'b1, 2'b01, 1'b0);
        // R6 RZ
        send(1'b1, 2'b10, 1'b0);
        send(1'b0, 2'b10, 1'b0);
        // R7 Manchester
        send(1'b0, 2'b11, 1'b0);
        send(1'b1, 2'b11, 1'b0);
        // R8: reference survives other modes
        send(1'b1, 2'b01, 1'b0);
        send(1'b1, 2'b10, 1'b0);
        send(1'b1, 2'b11, 1'b0);
        send(1'b1, 2'b00, 1'b0);
        send(1'b0, 2'b01, 1'b0);
        // R3: inputs changed during the lead half
        for (int m = 0; m < 4; m++) begin
            send(1'b1, 2'(m), 1'b1);
            send(1'b0, 2'(m), 1'b1);
        end
        // R1: reset mid-stream clears the NRZI reference
        send(1'b1, 2'b01, 1'b0);
        do_reset();
        send(1'b0, 2'b01, 1'b0);
        // Random stream
        for (int i = 0; i < 400; i++) begin
            send(1'($urandom), 2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule